// File: doc/BRIEF.md
# Loop-Bounded Program Counter

This block keeps the instruction pointer of one processing element that runs a short program out of a small configuration store. Each enabled cycle it moves to the next slot. Two registers inside the block hold a hardware loop window. When the pointer sits on the window's upper bound and is told to step, it returns to the lower bound instead of moving on.

A jump instruction, already decoded elsewhere, presents new lower and upper loop bounds, an optional explicit destination, and a valid strobe. The block loads both bounds. It moves the pointer to the explicit destination if one is given, and otherwise to the new lower bound. One cycle later it raises a pulse that tells the neighbouring logic to clear its predicate register. The pointer is 5 bits wide by default, which matches a 5-bit destination field.

Top module: `pe_loop_pc`

## Requirements
- R1: During reset and just after it, `pc` is 0 and `pred_clr` is 0. The internal loop lower bound resets to 0 and the upper bound resets to all ones (31 for the default width).
- R2: A jump with `jmp_has_dst` = 1 makes `pc` equal `jmp_dst` on the next cycle.
- R3: A jump with `jmp_has_dst` = 0 makes `pc` equal `jmp_lstart` on the next cycle.
- R4: With no jump and `step_en` = 1, if `pc` equals the loop upper bound, the next `pc` is the loop lower bound.
- R5: With no jump and `step_en` = 1, if `pc` differs from the upper bound, the next `pc` is `pc` + 1, wrapping modulo 2^PC_W.
- R6: With no jump and `step_en` = 0, `pc` keeps its value.
- R7: A jump overrides both the upper-bound wraparound and `step_en`. It takes effect whether or not `step_en` is high.
- R8: `pred_clr` is 1 for exactly the one cycle that follows each accepted jump, and 0 at all other times.
- R9: A jump replaces both loop bounds, and later wraparounds use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the pointer this cycle |
| jmp_valid | input | 1 | Decoded jump present this cycle |
| jmp_has_dst | input | 1 | Jump carries an explicit destination |
| jmp_dst | input | PC_W | Explicit jump destination |
| jmp_lstart | input | PC_W | New loop lower bound |
| jmp_lend | input | PC_W | New loop upper bound |
| pc | output | PC_W | Current program counter |
| pred_clr | output | 1 | One-cycle request to clear the predicate register |

## Verification
The loop bounds are not visible at the ports, so a wrong bound shows up only when the pointer reaches the upper bound and wraps. That can be up to 2^PC_W steps after the bound was written. A stuck bound therefore needs long stepping runs between jumps to be caught. The bench uses directed walks through a full window and mixes them with random runs in which jumps are rare. A wrong pointer update or a misplaced predicate pulse shows on the very next cycle.

// File: rtl/pe_loop_pc.sv
module pe_loop_pc #(
  parameter int PC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            jmp_valid,
  input  logic            jmp_has_dst,
  input  logic [PC_W-1:0] jmp_dst,
  input  logic [PC_W-1:0] jmp_lstart,
  input  logic [PC_W-1:0] jmp_lend,
  output logic [PC_W-1:0] pc,
  output logic            pred_clr
);
  localparam logic [PC_W-1:0] LEND_RST = '1;

  logic [PC_W-1:0] lstart_q, lend_q, pc_q, pc_d;
  logic            clr_q;

  wire at_end = (pc_q == lend_q);

  always_comb begin
    pc_d = pc_q;
    if (jmp_valid)
      pc_d = jmp_has_dst ? jmp_dst : jmp_lstart;
    else if (step_en)
      pc_d = at_end ? lstart_q : pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      lstart_q <= '0;
      lend_q   <= LEND_RST;
      clr_q    <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      clr_q <= jmp_valid;
      if (jmp_valid) begin
        lstart_q <= jmp_lstart;
        lend_q   <= jmp_lend;
      end
    end
  end

  assign pc       = pc_q;
  assign pred_clr = clr_q;

  logic live;
  always_ff @(posedge clk) live <= rst_n;

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (pc == '0 && !pred_clr)); // R1
  AST_JUMP_DST: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(jmp_valid) && $past(jmp_has_dst) |-> pc == $past(jmp_dst)); // R2
  AST_JUMP_LSTART: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(jmp_valid) && !$past(jmp_has_dst) |-> pc == $past(jmp_lstart)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(jmp_valid) && $past(step_en) && $past(pc) == $past(lend_q)
    |-> pc == $past(lstart_q)); // R4
  AST_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(jmp_valid) && $past(step_en) && $past(pc) != $past(lend_q)
    |-> pc == $past(pc) + 1'b1); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(jmp_valid) && !$past(step_en) |-> $stable(pc)); // R6
  AST_PRED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(jmp_valid) |-> pred_clr); // R8
  AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(jmp_valid) |-> !pred_clr); // R8
endmodule

// File: tb/tb_pe_loop_pc.sv
module tb_pe_loop_pc;
  localparam int PC_W = 5;
  localparam int MAXV = (1 << PC_W) - 1;

  logic clk = 0, rst_n = 0;
  logic step_en = 0, jmp_valid = 0, jmp_has_dst = 0;
  logic [PC_W-1:0] jmp_dst = '0, jmp_lstart = '0, jmp_lend = '0;
  logic [PC_W-1:0] pc;
  logic pred_clr;

  int total = 0, bad = 0;
  int m_pc, m_ls, m_le, m_clr;
  bit done = 0;

  always #5 clk = ~clk;

  pe_loop_pc #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jmp_valid(jmp_valid),
    .jmp_has_dst(jmp_has_dst), .jmp_dst(jmp_dst), .jmp_lstart(jmp_lstart),
    .jmp_lend(jmp_lend), .pc(pc), .pred_clr(pred_clr));

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int next_pc(bit j, bit hd, int d, int ls, bit st, int p, int le, int mls);
    if (j) return hd ? d : ls;
    if (!st) return p;
    if (p == le) return mls;
    return (p + 1) & MAXV;
  endfunction

  function automatic string tag_of(bit j, bit hd, bit st, int p, int le);
    if (j) return (st && p == le) ? "R7" : (hd ? "R2" : "R3");
    if (!st) return "R6";
    return (p == le) ? "R4" : "R5";
  endfunction

  task automatic cyc(bit j, bit hd, int d, int ls, int le, bit st, string force_tag = "");
    string t;
    jmp_valid = j; jmp_has_dst = hd; jmp_dst = d[PC_W-1:0];
    jmp_lstart = ls[PC_W-1:0]; jmp_lend = le[PC_W-1:0]; step_en = st;
    t = (force_tag != "") ? force_tag : tag_of(j, hd, st, m_pc, m_le);
    @(posedge clk);
    m_pc = next_pc(j, hd, d, ls, st, m_pc, m_le, m_ls);
    if (j) begin m_ls = ls; m_le = le; end
    m_clr = j;
    #1;
    check(t, pc, m_pc);
    check("R8", pred_clr, m_clr);
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 32'd20240517;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", pc, 0);
    check("R1", pred_clr, 0);
    rst_n = 1;
    m_pc = 0; m_ls = 0; m_le = MAXV; m_clr = 0;
    // R1: reset bounds 0..31, walk full range and wrap
    for (int i = 0; i < MAXV; i++) cyc(0, 0, 0, 0, 0, 1);
    check("R1", pc, MAXV);
    cyc(0, 0, 0, 0, 0, 1, "R1");
    check("R1", pc, 0);
    // R6 hold
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    // R2 explicit destination, R9 new bounds 3..6
    cyc(1, 1, 5, 3, 6, 1);
    cyc(0, 0, 0, 0, 0, 1);
    check("R9", pc, 6);
    cyc(0, 0, 0, 0, 0, 1, "R9");
    check("R9", pc, 3);
    // R3 default destination
    cyc(1, 0, 17, 9, 11, 0);
    check("R3", pc, 9);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    // R7 jump while at upper bound with step
    cyc(1, 1, 20, 2, 4, 1);
    check("R7", pc, 20);
    // R7 jump with step low
    cyc(1, 0, 0, 12, 13, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1, "R4");
    check("R4", pc, 12);
    // back-to-back jumps
    cyc(1, 1, 7, 7, 7, 1);
    cyc(1, 1, 1, 0, 2, 1);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit j;
      j = ($urandom % 10) == 0;
      cyc(j, $urandom % 2, $urandom % 32, $urandom % 32, $urandom % 32, ($urandom % 4) != 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule